// File: doc/BRIEF.md
# Bus Remote Wake-Up Detector

This block watches the receive level of a single-wire serial bus while the surrounding transceiver sits in its low-power state, and raises a one-cycle wake pulse when it sees a valid remote wake pattern. The bus level and a local wake pin arrive asynchronously. Each passes through a two-flop synchroniser before any edge or duration logic looks at it.

A parameter picks one of two detection variants. The low-level variant fires once the bus has been low for more than a short debounce time. The rising-edge variant waits for the bus to return high after a low of at least a longer debounce time. A bus that floats low and stays there therefore never wakes the system in the rising-edge variant. A falling edge on the local wake pin wakes the system in either variant.

Detection runs only while the arm input is high, which the power controller holds high in power-down. After the block fires it stays quiet until the arm input goes low and then high again. Debounce lengths are given in clock cycles, and the duration counter saturates rather than wrapping.

Top module: `bus_wake_detect`

## Requirements
- R1: With MODE = WAKE_ON_LOW, a bus low held for more than SHORT_CYC input cycles makes wake_o rise at the (SHORT_CYC+3)-th rising clock edge after the input fell. A low of SHORT_CYC cycles or fewer gives no wake.
- R2: With MODE = WAKE_ON_RISE, a bus low of at least LONG_CYC cycles followed by a return high makes wake_o rise at the 3rd rising edge after the input returned high. A low of LONG_CYC-1 cycles gives no wake.
- R3: With MODE = WAKE_ON_RISE, a low that never returns high while armed gives no wake. A low far longer than LONG_CYC still qualifies, because the counter saturates.
- R4: A high between two lows restarts the duration, so two short lows never add up to a qualifying low.
- R5: A falling edge of the local wake pin makes wake_o rise at the 3rd rising edge after the pin fell, in either mode. A rising edge of the pin produces nothing.
- R6: While arm_i is low, no bus pattern or pin edge produces a wake, and bus activity in that time does not count toward a later wake.
- R7: wake_o is high for exactly one cycle. After it fires, no further wake occurs until arm_i has been low and then high again.
- R8: After reset wake_o is 0. The synchronisers reset to the idle high level.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Detector clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| arm_i | input | 1 | High while the low-power state is active (synchronous) |
| bus_rx_i | input | 1 | Asynchronous digital bus receive level, 1 = recessive/high |
| wake_pin_i | input | 1 | Asynchronous local wake pin, active on its falling edge |
| wake_o | output | 1 | One-cycle wake request pulse |

## Verification
If the duration counter is wrong, the wake pulse shows up at the ports in the wrong cycle or not at all. A counter that accumulates across highs, or that wraps, gives an extra wake or a missing one within a few cycles of the pattern's end. A stuck fired flag shows as a missing wake after re-arming. A cleared fired flag shows as a second pulse on the next pattern. Because every expected wake is placed in one exact cycle, an off-by-one in either debounce threshold or in the synchroniser depth is seen as a timing mismatch, not only as a missing event.

// File: rtl/bwd_pkg.sv
package bwd_pkg;

  typedef enum logic {
    WAKE_ON_LOW  = 1'b0,
    WAKE_ON_RISE = 1'b1
  } wake_mode_e;

  // Next value of the saturating low-duration counter.
  function automatic int unsigned sat_step(int unsigned cur, int unsigned lim, bit clr);
    if (clr) return 0;
    if (cur >= lim) return lim;
    return cur + 1;
  endfunction

endpackage

// File: rtl/bwd_sync.sv
module bwd_sync #(
  parameter int unsigned W       = 1,
  parameter int unsigned STAGES  = 2,
  parameter logic [W-1:0] RST_VAL = '1
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [W-1:0] d_i,
  output logic [W-1:0] q_o
);
  logic [W-1:0] stg [STAGES];

  for (genvar s = 0; s < STAGES; s++) begin : g_stage
    if (s == 0) begin : g_first
      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) stg[s] <= RST_VAL;
        else        stg[s] <= d_i;
      end
    end else begin : g_next
      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) stg[s] <= RST_VAL;
        else        stg[s] <= stg[s-1];
      end
    end
  end

  assign q_o = stg[STAGES-1];
endmodule

// File: rtl/bwd_low_timer.sv
module bwd_low_timer #(
  parameter int unsigned LIMIT = 8,
  localparam int unsigned CNT_W = $clog2(LIMIT + 1)
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             clr_i,
  output logic [CNT_W-1:0] cnt_o,
  output logic             full_o
);
  logic [CNT_W-1:0] cnt_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) cnt_q <= '0;
    else        cnt_q <= CNT_W'(bwd_pkg::sat_step(int'(cnt_q), LIMIT, clr_i));
  end

  assign cnt_o  = cnt_q;
  assign full_o = (cnt_q == CNT_W'(LIMIT));
endmodule

// File: rtl/bwd_arm_ctrl.sv
module bwd_arm_ctrl (
  input  logic clk,
  input  logic rst_n,
  input  logic arm_i,
  input  logic req_i,
  output logic active_o,
  output logic fired_o,
  output logic wake_o
);
  logic fired_q;
  logic wake_q;

  assign active_o = arm_i && !fired_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      fired_q <= 1'b0;
      wake_q  <= 1'b0;
    end else begin
      wake_q <= active_o && req_i;
      if (!arm_i)                 fired_q <= 1'b0;
      else if (active_o && req_i) fired_q <= 1'b1;
    end
  end

  assign fired_o = fired_q;
  assign wake_o  = wake_q;
endmodule

// File: rtl/bus_wake_detect.sv
module bus_wake_detect #(
  parameter bwd_pkg::wake_mode_e MODE = bwd_pkg::WAKE_ON_LOW,
  parameter int unsigned SHORT_CYC   = 8,
  parameter int unsigned LONG_CYC    = 20,
  parameter int unsigned SYNC_STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic arm_i,
  input  logic bus_rx_i,
  input  logic wake_pin_i,
  output logic wake_o
);
  localparam int unsigned LOW_LIMIT = (MODE == bwd_pkg::WAKE_ON_RISE) ? LONG_CYC : SHORT_CYC;
  localparam int unsigned CNT_W     = $clog2(LOW_LIMIT + 1);

  logic [1:0]       sync_q;
  logic             bus_s;
  logic             pin_s;
  logic             pin_q;
  logic             pin_fall;
  logic             active;
  logic             fired;
  logic             low_full;
  logic [CNT_W-1:0] low_cnt;
  logic             bus_req;
  logic             wake_req;

  bwd_sync #(.W(2), .STAGES(SYNC_STAGES), .RST_VAL(2'b11)) i_sync (
    .clk  (clk),
    .rst_n(rst_n),
    .d_i  ({wake_pin_i, bus_rx_i}),
    .q_o  (sync_q)
  );
  assign bus_s = sync_q[0];
  assign pin_s = sync_q[1];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) pin_q <= 1'b1;
    else        pin_q <= pin_s;
  end
  assign pin_fall = pin_q && !pin_s;

  bwd_low_timer #(.LIMIT(LOW_LIMIT)) i_timer (
    .clk   (clk),
    .rst_n (rst_n),
    .clr_i (bus_s || !active),
    .cnt_o (low_cnt),
    .full_o(low_full)
  );

  if (MODE == bwd_pkg::WAKE_ON_RISE) begin : g_rise
    // Bus is back high this cycle and the counter still holds the low length.
    assign bus_req = bus_s && low_full;
  end else begin : g_low
    assign bus_req = !bus_s && low_full;
  end

  assign wake_req = bus_req || pin_fall;

  bwd_arm_ctrl i_arm (
    .clk     (clk),
    .rst_n   (rst_n),
    .arm_i   (arm_i),
    .req_i   (wake_req),
    .active_o(active),
    .fired_o (fired),
    .wake_o  (wake_o)
  );
endmodule

// File: rtl/bwd_checker.sv
module bwd_checker #(
  parameter bwd_pkg::wake_mode_e MODE = bwd_pkg::WAKE_ON_LOW,
  parameter int unsigned LIMIT = 8,
  parameter int unsigned CNT_W = 4
) (
  input logic             clk,
  input logic             rst_n,
  input logic             arm_i,
  input logic             bus_s,
  input logic             pin_fall,
  input logic             fired,
  input logic [CNT_W-1:0] low_cnt,
  input logic             wake_o
);
  a_r7_single_pulse: assert property (@(posedge clk) disable iff (!rst_n)
    wake_o |=> !wake_o);

  a_r6_only_when_armed: assert property (@(posedge clk) disable iff (!rst_n)
    wake_o |-> $past(arm_i));

  a_r7_fired_blocks: assert property (@(posedge clk) disable iff (!rst_n)
    (fired && arm_i) |=> !wake_o);

  a_r4_high_clears: assert property (@(posedge clk) disable iff (!rst_n)
    bus_s |=> (low_cnt == '0));

  a_r3_no_overflow: assert property (@(posedge clk) disable iff (!rst_n)
    low_cnt <= CNT_W'(LIMIT));

  if (MODE == bwd_pkg::WAKE_ON_RISE) begin : g_rise
    a_r2_after_high: assert property (@(posedge clk) disable iff (!rst_n)
      wake_o |-> ($past(bus_s) || $past(pin_fall)));
  end else begin : g_low
    a_r1_while_low: assert property (@(posedge clk) disable iff (!rst_n)
      wake_o |-> (!$past(bus_s) || $past(pin_fall)));
  end
endmodule

bind bus_wake_detect bwd_checker #(.MODE(MODE), .LIMIT(LOW_LIMIT), .CNT_W(CNT_W)) i_chk (
  .clk     (clk),
  .rst_n   (rst_n),
  .arm_i   (arm_i),
  .bus_s   (bus_s),
  .pin_fall(pin_fall),
  .fired   (fired),
  .low_cnt (low_cnt),
  .wake_o  (wake_o)
);

// File: tb/test_bus_wake_detect.sv
`timescale 1ns/1ps
module test_bus_wake_detect;
  localparam int SHORT = 8;
  localparam int LONG  = 20;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic arm = 1'b0;
  logic bus = 1'b1;
  logic pin = 1'b1;
  logic wake_lv, wake_rs;

  int cyc = 0;
  int checks = 0;
  int errors = 0;
  int unexp = 0;
  bit lv_armed = 0, rs_armed = 0;
  string cur_req = "R8";
  int q_lv[$];
  int q_rs[$];

  always #2.5 clk = ~clk;
  always @(posedge clk) cyc <= cyc + 1;

  bus_wake_detect #(.MODE(bwd_pkg::WAKE_ON_LOW), .SHORT_CYC(SHORT), .LONG_CYC(LONG)) i_bus_wake_detect (
    .clk(clk), .rst_n(rst_n), .arm_i(arm), .bus_rx_i(bus), .wake_pin_i(pin), .wake_o(wake_lv));

  bus_wake_detect #(.MODE(bwd_pkg::WAKE_ON_RISE), .SHORT_CYC(SHORT), .LONG_CYC(LONG)) i_bus_wake_detect_rise (
    .clk(clk), .rst_n(rst_n), .arm_i(arm), .bus_rx_i(bus), .wake_pin_i(pin), .wake_o(wake_rs));

  // Monitor: compare each observed wake with the scoreboard head.
  always @(negedge clk) begin
    if (rst_n) begin
      if (q_lv.size() != 0 && q_lv[0] < cyc) begin
        checks++; errors++;
        $display("FAIL %s low-mode wake missing: actual none expected cycle %0d", cur_req, q_lv[0]);
        void'(q_lv.pop_front());
      end
      if (q_rs.size() != 0 && q_rs[0] < cyc) begin
        checks++; errors++;
        $display("FAIL %s rise-mode wake missing: actual none expected cycle %0d", cur_req, q_rs[0]);
        void'(q_rs.pop_front());
      end
      if (wake_lv) begin
        if (q_lv.size() == 0) unexp++;
        else begin
          checks++;
          if (q_lv[0] != cyc) begin
            errors++;
            $display("FAIL %s low-mode wake: actual cycle %0d expected %0d", cur_req, cyc, q_lv[0]);
          end
          void'(q_lv.pop_front());
        end
      end
      if (wake_rs) begin
        if (q_rs.size() == 0) unexp++;
        else begin
          checks++;
          if (q_rs[0] != cyc) begin
            errors++;
            $display("FAIL %s rise-mode wake: actual cycle %0d expected %0d", cur_req, cyc, q_rs[0]);
          end
          void'(q_rs.pop_front());
        end
      end
    end
  end

  task automatic wait_cyc(int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic rearm();
    arm = 1'b0; wait_cyc(2);
    arm = 1'b1; lv_armed = 1; rs_armed = 1;
    wait_cyc(4);
  endtask

  // Driver: bus low for len cycles, then high; pushes expected wakes.
  task automatic low_pulse(int len);
    int c;
    c = cyc;
    bus = 1'b0;
    if (lv_armed && len > SHORT) begin q_lv.push_back(c + SHORT + 3); lv_armed = 0; end
    if (rs_armed && len >= LONG) begin q_rs.push_back(c + len + 3); rs_armed = 0; end
    wait_cyc(len);
    bus = 1'b1;
  endtask

  task automatic pin_fall();
    int c;
    c = cyc;
    pin = 1'b0;
    if (lv_armed) begin q_lv.push_back(c + 3); lv_armed = 0; end
    if (rs_armed) begin q_rs.push_back(c + 3); rs_armed = 0; end
    wait_cyc(5);
    pin = 1'b1;
    wait_cyc(5);
  endtask

  task automatic settle(string req);
    wait_cyc(30);
    checks++;
    if (q_lv.size() != 0 || q_rs.size() != 0 || unexp != 0) begin
      errors++;
      $display("FAIL %s scenario: actual unexpected=%0d pending=%0d expected 0 and 0",
               req, unexp, q_lv.size() + q_rs.size());
    end
    unexp = 0;
  endtask

  initial begin
    wait_cyc(3);
    checks += 2;
    if (wake_lv !== 1'b0) begin errors++; $display("FAIL R8 reset low-mode wake: actual %b expected 0", wake_lv); end
    if (wake_rs !== 1'b0) begin errors++; $display("FAIL R8 reset rise-mode wake: actual %b expected 0", wake_rs); end
    rst_n = 1'b1;
    wait_cyc(3);

    cur_req = "R1"; rearm(); low_pulse(5);  settle("R1 short glitch");
    cur_req = "R1"; rearm(); low_pulse(8);  settle("R1 low of exactly SHORT");
    cur_req = "R1"; rearm(); low_pulse(9);  settle("R1 low of SHORT+1");
    // R7: low-mode DUT already fired; without re-arm only rise-mode may fire
    cur_req = "R7"; low_pulse(20); settle("R7 no second wake before re-arm");
    cur_req = "R4"; rearm();
    bus = 1'b0; wait_cyc(6); bus = 1'b1; wait_cyc(2); bus = 1'b0; wait_cyc(6); bus = 1'b1;
    settle("R4 split lows");
    cur_req = "R2"; rearm(); low_pulse(20); settle("R2 low of LONG");
    cur_req = "R2"; rearm(); low_pulse(19); settle("R2 low of LONG-1");
    cur_req = "R3"; rearm(); low_pulse(40); settle("R3 saturated long low");
    cur_req = "R3"; rearm();
    begin
      int c;
      c = cyc; bus = 1'b0;
      q_lv.push_back(c + SHORT + 3); lv_armed = 0;
      wait_cyc(60);
      arm = 1'b0; lv_armed = 0; rs_armed = 0;
      wait_cyc(3);
      bus = 1'b1;
    end
    settle("R3 stuck low then disarm");
    cur_req = "R5"; rearm(); pin_fall(); settle("R5 pin falling edge");
    cur_req = "R6"; arm = 1'b0; lv_armed = 0; rs_armed = 0; wait_cyc(3);
    pin_fall(); low_pulse(30); settle("R6 activity while disarmed");
    cur_req = "R5"; pin = 1'b0; wait_cyc(4); rearm(); pin = 1'b1; settle("R5 pin rising edge");
    cur_req = "R7"; pin_fall(); pin_fall(); low_pulse(9); settle("R7 pulse once then quiet");

    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    wait (cyc > 100000);
    errors++; checks++;
    $display("FAIL watchdog: actual cycle %0d expected completion", cyc);
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule